// File: doc/BRIEF.md
# Trusted-Line Ownership Checker

This block lives in a memory-expansion device, between the host link and the memory array. It keeps a single ownership bit for every 64-byte line of device memory, marking whether the line holds data of a trusted execution environment or ordinary data. Each incoming read or write carries a trust-intent bit from its initiator. The block compares that intent against the stored bit and returns a completion or an access-violation status. On a violation, the data path zeroes the read data or drops the write.

Ownership changes in two ways. When implicit update is enabled, every allowed write copies its intent into the target line's bit. A bulk command sets or clears all 64 lines of one 4 KiB region. The bulk command walks the lines at one line per cycle and holds back requests that target the region while it runs. The device advertises which checks it supports, reads and/or writes, through a build-time capability field. The host turns checks on through a control register, and a check that is not enabled is never applied. The state array sits in a block-RAM-style memory. After reset the block sweeps the array to untrusted before it accepts any traffic. A saturating counter records violations, and a sticky register records the line of the first one.

Top module: `tes_access_ctrl`

## Requirements
- R1: After reset, ctl_o is 0, viol_count_o is 0 and first_viol_valid_o is 0. req_ready_o and cmd_ready_o stay low while every line is cleared to untrusted. After that, no untrusted request violates anywhere.
- R2: cap_o reports bit0 = read check supported and bit1 = write check supported. The control register bits are bit0 read check, bit1 write check and bit2 implicit update. A written control bit for an unsupported check reads back as 0.
- R3: A request with trusted intent (req_trusted_i=1) never gets rsp_err_o=1.
- R4: An untrusted-intent read of a trusted line gets rsp_err_o=1 when the read check is enabled, and rsp_err_o=0 when it is not.
- R5: An untrusted-intent write to a trusted line with the write check enabled gets rsp_err_o=1 and leaves the line's state unchanged.
- R6: When implicit update is enabled, an allowed write sets the line's state to its intent. When it is disabled, writes never change state.
- R7: A bulk command (cmd_set_i=1 trusted, 0 untrusted) updates every line of region cmd_region_i, whose lines are those with line index bits [LINE_AW-1:6] equal to the region. No line outside the region changes. cmd_ready_o stays low for at least 64 cycles after acceptance.
- R8: While a bulk command runs, requests whose line lies in its region are not accepted. Requests to other regions are accepted.
- R9: Each accepted request yields exactly one response with rsp_valid_o=1, two cycles after acceptance. A request accepted in the cycle right after a state-changing write to the same line sees the updated state.
- R10: viol_count_o counts violating responses and saturates at its maximum. first_viol_line_o holds the line of the first violation since reset, with first_viol_valid_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_o | output | 2 | Supported checks: bit0 read, bit1 write |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data: bit0 read check, bit1 write check, bit2 implicit update |
| ctl_o | output | 3 | Control register value |
| cmd_valid_i | input | 1 | Bulk region command request |
| cmd_ready_o | output | 1 | Bulk command accepted when high with cmd_valid_i |
| cmd_region_i | input | LINE_AW-6 | Region index of the command |
| cmd_set_i | input | 1 | 1 marks region trusted, 0 untrusted |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Access request accepted when high with req_valid_i |
| req_write_i | input | 1 | 1 write, 0 read |
| req_trusted_i | input | 1 | Trust intent of the initiator |
| req_line_i | input | LINE_AW | Line index of the access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_write_o | output | 1 | Response belongs to a write |
| rsp_err_o | output | 1 | Violation: zero read data or drop write |
| viol_count_o | output | CNT_W | Saturating violation count |
| first_viol_valid_o | output | 1 | A violation has been recorded |
| first_viol_line_o | output | LINE_AW | Line of the first violation |

## Verification
The bench first aims at the same-line hazard. A trusted write that flips a line is followed in the next cycle by an untrusted read of that line; a design without forwarding from the pending update would read the stale RAM value and complete the read without error. It then checks that a blocked write really leaves the state alone, through a later read that must still fault; a design that updated state before the verdict would let that read pass. It probes the region edges, the lines just inside and just outside the 64-line window, and the stall of a request to the busy region while another region proceeds, where wrong address slicing would let a request through or block it. A second instance with no write-check support and a 2-bit counter shows the capability mask and counter saturation; a design that got either wrong would fault the write or wrap the count to zero.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int CTL_W   = 3;
  localparam int CTL_RD  = 0;
  localparam int CTL_WR  = 1;
  localparam int CTL_IMP = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_INIT   = 2'd1,
    SEQ_REGION = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/tes_state_ram.sv
module tes_state_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tes_region_seq.sv
module tes_region_seq
  import tes_pkg::*;
#(
  parameter int LINE_AW   = 10,
  parameter int REGION_LW = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid_i,
  input  logic [LINE_AW-REGION_LW-1:0] cmd_region_i,
  input  logic                         cmd_set_i,
  input  logic                         port_free_i,
  output logic                         cmd_ready_o,
  output logic                         init_o,
  output logic                         rgn_busy_o,
  output logic [LINE_AW-REGION_LW-1:0] rgn_o,
  output logic                         we_o,
  output logic [LINE_AW-1:0]           waddr_o,
  output logic                         wdata_o
);
  localparam int RG_AW = LINE_AW - REGION_LW;

  seq_mode_e        mode;
  logic [LINE_AW-1:0] cnt;
  logic             val;
  logic             last;

  assign last = (mode == SEQ_INIT) ? (&cnt) : (&cnt[REGION_LW-1:0]);

  assign we_o        = (mode != SEQ_IDLE) && port_free_i;
  assign waddr_o     = cnt;
  assign wdata_o     = val;
  assign cmd_ready_o = (mode == SEQ_IDLE) && !rst;
  assign init_o      = (mode == SEQ_INIT);
  assign rgn_busy_o  = (mode == SEQ_REGION);
  assign rgn_o       = cnt[LINE_AW-1:REGION_LW];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= SEQ_INIT;
      cnt  <= '0;
      val  <= 1'b0;
    end else begin
      case (mode)
        SEQ_IDLE: begin
          if (cmd_valid_i) begin
            mode <= SEQ_REGION;
            cnt  <= {cmd_region_i, {REGION_LW{1'b0}}};
            val  <= cmd_set_i;
          end
        end
        SEQ_INIT, SEQ_REGION: begin
          if (we_o) begin
            cnt <= cnt + 1'b1;
            if (last) mode <= SEQ_IDLE;
          end
        end
        default: mode <= SEQ_IDLE;
      endcase
    end
  end

  AST_CMD_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R7

  AST_SWEEP_STAYS_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_REGION && !last) |=> (cnt[LINE_AW-1:REGION_LW] == $past(cnt[LINE_AW-1:REGION_LW]))); // R7

  initial begin
    assert (RG_AW >= 1) else $error("region field must be at least one bit");
  end
endmodule

// File: rtl/tes_verdict.sv
module tes_verdict
  import tes_pkg::*;
#(
  parameter int LINE_AW = 10,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  logic               write_i,
  input  logic               trusted_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic               state_i,
  input  logic [CTL_W-1:0]   ctl_i,
  output logic               viol_o,
  output logic               upd_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               first_vld_o,
  output logic [LINE_AW-1:0] first_line_o
);
  logic chk_en;

  assign chk_en = write_i ? ctl_i[CTL_WR] : ctl_i[CTL_RD];
  assign viol_o = vld_i && !trusted_i && state_i && chk_en;
  assign upd_o  = vld_i && write_i && ctl_i[CTL_IMP] && !viol_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o        <= '0;
      first_vld_o  <= 1'b0;
      first_line_o <= '0;
    end else begin
      if (viol_o && (cnt_o != {CNT_W{1'b1}})) cnt_o <= cnt_o + 1'b1;
      if (viol_o && !first_vld_o) begin
        first_vld_o  <= 1'b1;
        first_line_o <= line_i;
      end
    end
  end

  AST_COUNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    cnt_o >= $past(cnt_o)); // R10

  AST_FIRST_IS_STICKY: assert property (@(posedge clk) disable iff (rst)
    first_vld_o |=> (first_vld_o && $stable(first_line_o))); // R10
endmodule

// File: rtl/tes_access_ctrl.sv
module tes_access_ctrl
  import tes_pkg::*;
#(
  parameter int LINE_AW    = 10,
  parameter int REGION_LW  = 6,
  parameter int CNT_W      = 16,
  parameter bit SUPPORT_RD = 1'b1,
  parameter bit SUPPORT_WR = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [1:0]                   cap_o,
  input  logic                         ctl_we_i,
  input  logic [2:0]                   ctl_wdata_i,
  output logic [2:0]                   ctl_o,
  input  logic                         cmd_valid_i,
  output logic                         cmd_ready_o,
  input  logic [LINE_AW-REGION_LW-1:0] cmd_region_i,
  input  logic                         cmd_set_i,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic                         req_write_i,
  input  logic                         req_trusted_i,
  input  logic [LINE_AW-1:0]           req_line_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_write_o,
  output logic                         rsp_err_o,
  output logic [CNT_W-1:0]             viol_count_o,
  output logic                         first_viol_valid_o,
  output logic [LINE_AW-1:0]           first_viol_line_o
);
  localparam int RG_AW = LINE_AW - REGION_LW;
  localparam logic [CTL_W-1:0] CTL_MASK = {1'b1, SUPPORT_WR, SUPPORT_RD};

  logic [CTL_W-1:0]   ctl_q;
  logic               seq_init, seq_busy, seq_we, seq_wdata;
  logic [RG_AW-1:0]   seq_rgn;
  logic [LINE_AW-1:0] seq_waddr;
  logic               req_fire, cmd_fire;
  logic               s1_vld, s1_wr, s1_tr;
  logic [LINE_AW-1:0] s1_line;
  logic               byp_hit, byp_val;
  logic               ram_rdata, s1_state;
  logic               viol, upd;
  logic               ram_we, ram_wdata;
  logic [LINE_AW-1:0] ram_waddr;
  logic               hit_busy, hit_new;

  assign cap_o = {SUPPORT_WR, SUPPORT_RD};
  assign ctl_o = ctl_q;

  always_ff @(posedge clk) begin
    if (rst)           ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i & CTL_MASK;
  end

  tes_region_seq #(
    .LINE_AW  (LINE_AW),
    .REGION_LW(REGION_LW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_region_i(cmd_region_i),
    .cmd_set_i   (cmd_set_i),
    .port_free_i (!upd),
    .cmd_ready_o (cmd_ready_o),
    .init_o      (seq_init),
    .rgn_busy_o  (seq_busy),
    .rgn_o       (seq_rgn),
    .we_o        (seq_we),
    .waddr_o     (seq_waddr),
    .wdata_o     (seq_wdata)
  );

  assign cmd_fire = cmd_valid_i && cmd_ready_o;
  assign hit_busy = seq_busy && (req_line_i[LINE_AW-1:REGION_LW] == seq_rgn);
  assign hit_new  = cmd_fire && (req_line_i[LINE_AW-1:REGION_LW] == cmd_region_i);
  assign req_ready_o = !rst && !seq_init && !hit_busy && !hit_new;
  assign req_fire    = req_valid_i && req_ready_o;

  assign ram_we    = upd || seq_we;
  assign ram_waddr = upd ? s1_line : seq_waddr;
  assign ram_wdata = upd ? s1_tr : seq_wdata;

  tes_state_ram #(.AW(LINE_AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(req_line_i),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_tr   <= 1'b0;
      s1_line <= '0;
      byp_hit <= 1'b0;
      byp_val <= 1'b0;
    end else begin
      s1_vld  <= req_fire;
      s1_wr   <= req_write_i;
      s1_tr   <= req_trusted_i;
      s1_line <= req_line_i;
      byp_hit <= upd && (s1_line == req_line_i);
      byp_val <= s1_tr;
    end
  end

  assign s1_state = byp_hit ? byp_val : ram_rdata;

  tes_verdict #(
    .LINE_AW(LINE_AW),
    .CNT_W  (CNT_W)
  ) u_verdict (
    .clk         (clk),
    .rst         (rst),
    .vld_i       (s1_vld),
    .write_i     (s1_wr),
    .trusted_i   (s1_tr),
    .line_i      (s1_line),
    .state_i     (s1_state),
    .ctl_i       (ctl_q),
    .viol_o      (viol),
    .upd_o       (upd),
    .cnt_o       (viol_count_o),
    .first_vld_o (first_viol_valid_o),
    .first_line_o(first_viol_line_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_write_o <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= s1_vld;
      rsp_write_o <= s1_wr;
      rsp_err_o   <= viol;
    end
  end

  AST_RSP_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> ##1 rsp_valid_o); // R9

  AST_TRUSTED_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (req_fire && req_trusted_i) |=> ##1 !rsp_err_o); // R3

  AST_NO_UPDATE_IN_BUSY_REGION: assert property (@(posedge clk) disable iff (rst)
    (upd && seq_busy) |-> (s1_line[LINE_AW-1:REGION_LW] != seq_rgn)); // R8

  AST_CTL_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
    ((ctl_o[1:0] & ~cap_o) == 2'b00)); // R2
endmodule

// File: tb/sim_tes_access_ctrl.sv
module sim_tes_access_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_viol = 0;
  bit done = 1'b0;

  // instance 0: defaults
  logic [1:0] cap0; logic c0_we = 0; logic [2:0] c0_wd = 0; logic [2:0] ctl0;
  logic m0_v = 0; logic m0_rdy; logic [3:0] m0_rg = 0; logic m0_set = 0;
  logic q0_v = 0; logic q0_rdy; logic q0_w = 0; logic q0_t = 0; logic [9:0] q0_l = 0;
  logic r0_v, r0_w, r0_e; logic [15:0] cnt0; logic fv0; logic [9:0] fl0;

  // instance 1: no write check, small counter
  logic [1:0] cap1; logic c1_we = 0; logic [2:0] c1_wd = 0; logic [2:0] ctl1;
  logic m1_v = 0; logic m1_rdy; logic [0:0] m1_rg = 0; logic m1_set = 0;
  logic q1_v = 0; logic q1_rdy; logic q1_w = 0; logic q1_t = 0; logic [6:0] q1_l = 0;
  logic r1_v, r1_w, r1_e; logic [1:0] cnt1; logic fv1; logic [6:0] fl1;

  tes_access_ctrl u0 (
    .clk(clk), .rst(rst), .cap_o(cap0), .ctl_we_i(c0_we), .ctl_wdata_i(c0_wd), .ctl_o(ctl0),
    .cmd_valid_i(m0_v), .cmd_ready_o(m0_rdy), .cmd_region_i(m0_rg), .cmd_set_i(m0_set),
    .req_valid_i(q0_v), .req_ready_o(q0_rdy), .req_write_i(q0_w), .req_trusted_i(q0_t),
    .req_line_i(q0_l), .rsp_valid_o(r0_v), .rsp_write_o(r0_w), .rsp_err_o(r0_e),
    .viol_count_o(cnt0), .first_viol_valid_o(fv0), .first_viol_line_o(fl0));

  tes_access_ctrl #(.LINE_AW(7), .REGION_LW(6), .CNT_W(2), .SUPPORT_RD(1'b1), .SUPPORT_WR(1'b0)) u1 (
    .clk(clk), .rst(rst), .cap_o(cap1), .ctl_we_i(c1_we), .ctl_wdata_i(c1_wd), .ctl_o(ctl1),
    .cmd_valid_i(m1_v), .cmd_ready_o(m1_rdy), .cmd_region_i(m1_rg), .cmd_set_i(m1_set),
    .req_valid_i(q1_v), .req_ready_o(q1_rdy), .req_write_i(q1_w), .req_trusted_i(q1_t),
    .req_line_i(q1_l), .rsp_valid_o(r1_v), .rsp_write_o(r1_w), .rsp_err_o(r1_e),
    .viol_count_o(cnt1), .first_viol_valid_o(fv1), .first_viol_line_o(fl1));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic set_ctl(input bit which, input logic [2:0] d);
    @(negedge clk);
    if (which) begin c1_we = 1; c1_wd = d; end else begin c0_we = 1; c0_wd = d; end
    @(negedge clk);
    c0_we = 0; c1_we = 0;
  endtask

  // one request, response sampled two cycles after acceptance
  task automatic do_req(input bit which, input bit w, input bit t, input int line,
                        input bit exp_err, input string req);
    int guard;
    @(negedge clk);
    if (which) begin q1_v = 1; q1_w = w; q1_t = t; q1_l = line[6:0]; end
    else       begin q0_v = 1; q0_w = w; q0_t = t; q0_l = line[9:0]; end
    #1;
    guard = 0;
    while (!(which ? q1_rdy : q0_rdy) && guard < 5000) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    q0_v = 0; q1_v = 0;
    @(negedge clk);
    chk((which ? r1_v : r0_v) == 1'b1, req, $sformatf("rsp_valid line %0d", line),
        which ? r1_v : r0_v, 1);
    chk((which ? r1_e : r0_e) == exp_err, req, $sformatf("rsp_err line %0d", line),
        which ? r1_e : r0_e, exp_err);
    if (exp_err && !which) exp_viol++;
  endtask

  task automatic do_cmd(input bit which, input int rg, input bit set, output int cyc);
    @(negedge clk);
    if (which) begin m1_v = 1; m1_rg = rg[0:0]; m1_set = set; end
    else       begin m0_v = 1; m0_rg = rg[3:0]; m0_set = set; end
    #1;
    while (!(which ? m1_rdy : m0_rdy)) begin @(negedge clk); #1; end
    @(negedge clk);
    m0_v = 0; m1_v = 0;
    chk((which ? m1_rdy : m0_rdy) == 1'b0, "R7", "cmd_ready right after accept",
        which ? m1_rdy : m0_rdy, 0);
    cyc = 0;
    while (!(which ? m1_rdy : m0_rdy) && cyc < 1000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    int n;
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(q0_rdy == 0, "R1", "req_ready during clear", q0_rdy, 0);
    chk(m0_rdy == 0, "R1", "cmd_ready during clear", m0_rdy, 0);
    chk(ctl0 == 3'b000, "R1", "ctl after reset", ctl0, 0);
    chk(cnt0 == 0 && fv0 == 0, "R1", "violation log after reset", cnt0, 0);
    n = 0;
    while (!(q0_rdy && q1_rdy) && n < 3000) begin @(negedge clk); n++; end
    chk(n >= 1000, "R1", "cycles of initial clear", n, 1023);
  endtask

  task automatic t_caps();
    chk(cap0 == 2'b11, "R2", "cap full instance", cap0, 3);
    chk(cap1 == 2'b01, "R2", "cap read-only instance", cap1, 1);
    set_ctl(1, 3'b111);
    @(negedge clk);
    chk(ctl1 == 3'b101, "R2", "masked ctl readback", ctl1, 5);
    set_ctl(0, 3'b011);
    @(negedge clk);
    chk(ctl0 == 3'b011, "R2", "ctl readback", ctl0, 3);
  endtask

  task automatic t_after_init();
    do_req(0, 0, 0, 0, 0, "R1");
    do_req(0, 0, 0, 1023, 0, "R1");
    do_req(0, 1, 0, 512, 0, "R1");
  endtask

  task automatic t_busy_region();
    @(negedge clk);
    m0_v = 1; m0_rg = 4'd2; m0_set = 1;
    #1;
    @(negedge clk);
    m0_v = 0;
    q0_v = 1; q0_w = 0; q0_t = 0; q0_l = 10'd150;
    #1;
    chk(q0_rdy == 0, "R8", "ready for busy region", q0_rdy, 0);
    q0_l = 10'd200;
    #1;
    chk(q0_rdy == 1, "R8", "ready for other region", q0_rdy, 1);
    @(negedge clk);
    q0_v = 0;
    @(negedge clk);
    chk(r0_v == 1 && r0_e == 0, "R8", "other-region response", r0_e, 0);
    while (!m0_rdy) @(negedge clk);
  endtask

  task automatic t_region_checks();
    do_req(0, 0, 0, 128, 1, "R7");
    do_req(0, 0, 0, 191, 1, "R7");
    do_req(0, 0, 0, 192, 0, "R7");
    do_req(0, 0, 0, 127, 0, "R7");
    do_req(0, 0, 1, 128, 0, "R3");
    do_req(0, 1, 1, 130, 0, "R3");
    @(negedge clk);
    chk(fv0 == 1 && fl0 == 10'd128, "R10", "first violation line", fl0, 128);
  endtask

  task automatic t_read_check_off();
    set_ctl(0, 3'b010);
    do_req(0, 0, 0, 128, 0, "R4");
    set_ctl(0, 3'b011);
    do_req(0, 0, 0, 129, 1, "R4");
  endtask

  task automatic t_write_block();
    set_ctl(0, 3'b111);
    do_req(0, 1, 0, 140, 1, "R5");
    do_req(0, 0, 0, 140, 1, "R5");
  endtask

  task automatic t_implicit();
    set_ctl(0, 3'b111);
    do_req(0, 1, 1, 300, 0, "R6");
    do_req(0, 0, 0, 300, 1, "R6");
    set_ctl(0, 3'b101);
    do_req(0, 1, 0, 300, 0, "R6");
    do_req(0, 0, 0, 300, 0, "R6");
    set_ctl(0, 3'b001);
    do_req(0, 1, 1, 301, 0, "R6");
    do_req(0, 0, 0, 301, 0, "R6");
  endtask

  task automatic t_back_to_back();
    set_ctl(0, 3'b111);
    @(negedge clk);
    q0_v = 1; q0_w = 1; q0_t = 1; q0_l = 10'd400;
    @(negedge clk);
    q0_w = 0; q0_t = 0;
    @(negedge clk);
    q0_v = 0;
    chk(r0_v == 1 && r0_w == 1 && r0_e == 0, "R9", "first of pair", r0_e, 0);
    @(negedge clk);
    chk(r0_v == 1 && r0_w == 0, "R9", "second of pair valid", r0_v, 1);
    chk(r0_e == 1, "R9", "forwarded state on second", r0_e, 1);
    exp_viol++;
    @(negedge clk);
    chk(r0_v == 0, "R9", "no extra response", r0_v, 0);
  endtask

  task automatic t_clear_region();
    int cyc;
    do_cmd(0, 2, 0, cyc);
    chk(cyc >= 64 && cyc < 80, "R7", "bulk command duration", cyc, 64);
    do_req(0, 0, 0, 128, 0, "R7");
    do_req(0, 0, 0, 191, 0, "R7");
    @(negedge clk);
    chk(cnt0 == exp_viol, "R10", "violation count", cnt0, exp_viol);
    chk(fl0 == 10'd128, "R10", "first line kept", fl0, 128);
  endtask

  task automatic t_small_instance();
    int cyc;
    do_cmd(1, 0, 1, cyc);
    do_req(1, 1, 0, 5, 0, "R2");
    do_req(1, 0, 0, 5, 0, "R6");
    for (int i = 0; i < 4; i++) do_req(1, 0, 0, 6, 1, "R10");
    @(negedge clk);
    chk(cnt1 == 2'd3, "R10", "counter saturates", cnt1, 3);
    do_req(1, 0, 0, 70, 0, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_up();
  end

  initial begin
    t_reset();
    t_caps();
    t_after_init();
    t_busy_region();
    t_region_checks();
    t_read_check_off();
    t_write_block();
    t_implicit();
    t_back_to_back();
    t_clear_region();
    t_small_instance();
    finish_up();
  end
endmodule